// File: doc/BRIEF.md
# Page Table Address Translator

This block turns a virtual address into a physical address through a single-level page table that it holds internally. The page size is a power of two fixed at elaboration. The low bits of the virtual address are the in-page offset and the remaining upper bits index the table. Each request carries a virtual address and a read/write flag. The indexed entry is checked for presence and, on writes, for write permission. The block then answers with either a physical address or a fault code.

Software fills the table through a simple configuration port that writes one entry per cycle. The response is registered and appears one cycle after the request. An absent page or a write to a read-only page returns a fault instead of an address. No address arithmetic is used: the frame number and the offset are joined by concatenation.

Top module: `at_translator`

## Requirements
- R1: With `OFF_W` offset bits (page size 2^OFF_W bytes), the offset is `vaddr[OFF_W-1:0]` and the page index is `vaddr[VA_W-1:OFF_W]`. In the default configuration (VA_W=16, OFF_W=8) the index is `vaddr[15:8]`.
- R2: An entry written through `cfg_pte` is read as follows: bit 31 is the present flag, bit 30 is the read-only flag and bits `FRAME_W-1:0` are the frame number. All other bits have no effect on any response.
- R3: A successful translation returns `rsp_paddr = {frame, offset}`, with the offset passed through unchanged, together with `rsp_ok=1` and `rsp_fault=2'b00`.
- R4: If the indexed entry has bit 31 clear, the response is `rsp_fault=2'b01` (not present), `rsp_ok=0` and `rsp_paddr=0`.
- R5: A write request (`req_write=1`) to a present entry with bit 30 set returns `rsp_fault=2'b10`, `rsp_ok=0` and `rsp_paddr=0`. A read request to the same entry translates normally.
- R6: A request strobed on `req_valid` is answered exactly one clock later with `rsp_valid=1`. A cycle with no request gives `rsp_valid=0` and all other response fields zero in the following cycle. Back-to-back requests are each answered in turn.
- R7: Reset clears every entry and the response register. After reset, every translation returns the not-present fault until software writes entries.
- R8: A configuration write takes effect for requests in later cycles. A request in the same cycle as a write to the same index sees the old entry.
- R9: In the default configuration, with page 47 mapped to frame 10, virtual address 12107 (0x2F4B) translates to physical 2635 (0x0A4B).
- R10: The code 2'b11 is never produced. When an entry is both not present and read-only, a write reports not present (2'b01).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | VA_W | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| cfg_we | input | 1 | Table entry write enable |
| cfg_index | input | VA_W-OFF_W | Entry index to write |
| cfg_pte | input | 32 | Entry word (bit 31 present, bit 30 read-only, low bits frame) |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | FRAME_W+OFF_W | Physical address, zero on a fault |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_fault | output | 2 | 00 none, 01 not present, 10 write to read-only |

## Verification
The assertions assume that `req_valid` and `cfg_we` are low while reset is held, so that the cycle history seen after reset release is clean. They also assume that `cfg_pte` carries known values whenever `cfg_we` is high. The bench drives every input only on falling clock edges. It holds both strobes low throughout each reset and always presents a fully defined entry word, including junk in the ignored bits. This lets the write and the same-cycle collision be checked through the responses alone.

// File: rtl/at_pkg.sv
package at_pkg;
    localparam int PTE_W       = 32;
    localparam int PTE_PRESENT = 31;
    localparam int PTE_RDONLY  = 30;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_ABSENT = 2'b01,
        FLT_RDONLY = 2'b10
    } fault_e;
endpackage

// File: rtl/at_addr_split.sv
module at_addr_split #(
    parameter int VA_W  = 16,
    parameter int OFF_W = 8,
    localparam int IDX_W = VA_W - OFF_W
) (
    input  logic [VA_W-1:0]  vaddr,
    output logic [IDX_W-1:0] page_idx,
    output logic [OFF_W-1:0] page_off
);
    // power-of-two page: plain bit selection, no divide
    always_comb begin
        page_idx = vaddr[VA_W-1:OFF_W];
        page_off = vaddr[OFF_W-1:0];
    end

    initial begin
        assert (OFF_W > 0 && OFF_W < VA_W)
            else $error("offset width must leave index bits (R1)");
    end
endmodule

// File: rtl/at_page_table.sv
module at_page_table #(
    parameter int IDX_W   = 8,
    parameter int FRAME_W = 8,
    localparam int ENT_W  = FRAME_W + 2,
    localparam int DEPTH  = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ENT_W-1:0] wr_ent,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ENT_W-1:0] rd_ent
);
    // compact entry: {present, read_only, frame}
    logic [ENT_W-1:0] tbl_d [DEPTH];
    logic [ENT_W-1:0] tbl_q [DEPTH];

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d[wr_idx] = wr_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // read from registered state: same-cycle write is not visible yet
    assign rd_ent = tbl_q[rd_idx];

    p_cfg_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tbl_q[$past(wr_idx)] == $past(wr_ent))
        else $error("entry write not stored");
endmodule

// File: rtl/at_fault_check.sv
module at_fault_check
    import at_pkg::*;
#(
    parameter int FRAME_W = 8,
    localparam int ENT_W  = FRAME_W + 2
) (
    input  logic [ENT_W-1:0]   ent,
    input  logic               is_write,
    output logic [FRAME_W-1:0] frame,
    output fault_e             fault
);
    logic present;
    logic rdonly;

    always_comb begin
        present = ent[ENT_W-1];
        rdonly  = ent[ENT_W-2];
        frame   = ent[FRAME_W-1:0];
        // absence outranks protection
        if (!present) begin
            fault = FLT_ABSENT;
        end else if (is_write && rdonly) begin
            fault = FLT_RDONLY;
        end else begin
            fault = FLT_NONE;
        end
    end
endmodule

// File: rtl/at_translator.sv
module at_translator
    import at_pkg::*;
#(
    parameter int VA_W    = 16,
    parameter int OFF_W   = 8,
    parameter int FRAME_W = 8,
    localparam int IDX_W  = VA_W - OFF_W,
    localparam int PA_W   = FRAME_W + OFF_W,
    localparam int ENT_W  = FRAME_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_index,
    input  logic [31:0]      cfg_pte,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_ok,
    output logic [1:0]       rsp_fault
);
    typedef struct packed {
        logic            valid;
        logic            ok;
        fault_e          fault;
        logic [PA_W-1:0] paddr;
    } resp_t;

    resp_t resp_d, resp_q;

    logic [IDX_W-1:0]   page_idx;
    logic [OFF_W-1:0]   page_off;
    logic [ENT_W-1:0]   cfg_ent;
    logic [ENT_W-1:0]   look_ent;
    logic [FRAME_W-1:0] look_frame;
    fault_e             look_fault;

    at_addr_split #(.VA_W(VA_W), .OFF_W(OFF_W)) u_split (
        .vaddr    (req_vaddr),
        .page_idx (page_idx),
        .page_off (page_off)
    );

    // keep only the fields the lookup needs
    assign cfg_ent = {cfg_pte[PTE_PRESENT], cfg_pte[PTE_RDONLY], cfg_pte[FRAME_W-1:0]};

    at_page_table #(.IDX_W(IDX_W), .FRAME_W(FRAME_W)) u_table (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_idx (cfg_index),
        .wr_ent (cfg_ent),
        .rd_idx (page_idx),
        .rd_ent (look_ent)
    );

    at_fault_check #(.FRAME_W(FRAME_W)) u_check (
        .ent      (look_ent),
        .is_write (req_write),
        .frame    (look_frame),
        .fault    (look_fault)
    );

    always_comb begin
        resp_d = '0;
        if (req_valid) begin
            resp_d.valid = 1'b1;
            resp_d.fault = look_fault;
            if (look_fault == FLT_NONE) begin
                resp_d.ok    = 1'b1;
                resp_d.paddr = {look_frame, page_off};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_q <= '0;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign rsp_valid = resp_q.valid;
    assign rsp_ok    = resp_q.ok;
    assign rsp_fault = resp_q.fault;
    assign rsp_paddr = resp_q.paddr;

    p_cfg_known_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> !$isunknown(cfg_pte))
        else $error("unknown entry word");

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid)
        else $error("response missing");

    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid)
        else $error("spurious response");

    p_fault_noaddr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != 2'b00) |-> (!rsp_ok && rsp_paddr == '0))
        else $error("fault carried an address");

    p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_ok |-> rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]))
        else $error("offset altered");

    p_rdonly_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault == 2'b10) |-> $past(req_write))
        else $error("protection fault on a read");

    p_code_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault != 2'b11)
        else $error("illegal fault code");
endmodule

// File: tb/at_translator_bench.sv
module at_translator_bench;
    localparam int VA_W = 16;
    localparam int OFF_W = 8;
    localparam int FRAME_W = 8;
    localparam int IDX_W = VA_W - OFF_W;
    localparam int PA_W = FRAME_W + OFF_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [VA_W-1:0] req_vaddr = '0;
    logic req_write = 1'b0;
    logic cfg_we = 1'b0;
    logic [IDX_W-1:0] cfg_index = '0;
    logic [31:0] cfg_pte = '0;
    logic rsp_valid;
    logic [PA_W-1:0] rsp_paddr;
    logic rsp_ok;
    logic [1:0] rsp_fault;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    at_translator #(.VA_W(VA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) u_at_translator (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
        .cfg_we(cfg_we), .cfg_index(cfg_index), .cfg_pte(cfg_pte),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_ok(rsp_ok), .rsp_fault(rsp_fault)
    );

    typedef struct packed {
        logic [15:0] va;
        logic        wr;
        logic        ok;
        logic [1:0]  flt;
        logic [15:0] pa;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{16'h2F4B, 1'b0, 1'b1, 2'b00, 16'h0A4B},  // R9 12107 -> 2635
        '{16'h2F4B, 1'b1, 1'b1, 2'b00, 16'h0A4B},  // R3 write to writable page
        '{16'h05DB, 1'b0, 1'b1, 2'b00, 16'h06DB},  // R1 R3
        '{16'h0300, 1'b0, 1'b1, 2'b00, 16'h0600},  // R5 read of read-only page
        '{16'h03FF, 1'b1, 1'b0, 2'b10, 16'h0000},  // R5 protection fault
        '{16'h0712, 1'b1, 1'b0, 2'b01, 16'h0000},  // R10 absent beats read-only
        '{16'h0712, 1'b0, 1'b0, 2'b01, 16'h0000},  // R4 not present
        '{16'hC8FE, 1'b0, 1'b1, 2'b00, 16'hFFFE},  // R2 junk bits ignored
        '{16'h0100, 1'b0, 1'b0, 2'b01, 16'h0000}   // R4 never written
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_rsp(input string tag, input logic v, input logic ok,
                           input logic [1:0] flt, input logic [15:0] pa);
        chk({tag, " valid"}, 32'(rsp_valid), 32'(v));
        chk({tag, " ok"}, 32'(rsp_ok), 32'(ok));
        chk({tag, " fault"}, 32'(rsp_fault), 32'(flt));
        chk({tag, " paddr"}, 32'(rsp_paddr), 32'(pa));
    endtask

    task automatic cfg_write(input logic [IDX_W-1:0] idx, input logic [31:0] pte);
        @(negedge clk);
        cfg_we = 1'b1; cfg_index = idx; cfg_pte = pte;
        @(negedge clk);
        cfg_we = 1'b0; cfg_pte = '0;
    endtask

    // drive on a falling edge, sample at the next falling edge
    task automatic one_req(input logic [15:0] va, input logic wr);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk_rsp("R7 reset state", 1'b0, 1'b0, 2'b00, 16'h0);

        one_req(16'h2F4B, 1'b0);
        chk_rsp("R7 empty table", 1'b1, 1'b0, 2'b01, 16'h0);

        cfg_write(8'd47, 32'h8000_000A);
        cfg_write(8'd5, 32'h8000_0006);
        cfg_write(8'd3, 32'hC000_0006);
        cfg_write(8'd7, 32'h4000_0009);
        cfg_write(8'd200, 32'h9ABC_DEFF);

        for (int i = 0; i < NV; i++) begin
            one_req(VECS[i].va, VECS[i].wr);
            chk_rsp($sformatf("R3 vec%0d", i), 1'b1, VECS[i].ok, VECS[i].flt, VECS[i].pa);
        end

        // R6 idle cycle gives no response
        @(negedge clk);
        chk_rsp("R6 idle", 1'b0, 1'b0, 2'b00, 16'h0);

        // R6 back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = 16'h0511; req_write = 1'b0;
        @(negedge clk);
        chk_rsp("R6 first of pair", 1'b1, 1'b1, 2'b00, 16'h0611);
        req_vaddr = 16'h2F00; req_write = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk_rsp("R6 second of pair", 1'b1, 1'b1, 2'b00, 16'h0A00);

        // R8 same-cycle write and request on page 9: old contents used
        @(negedge clk);
        cfg_we = 1'b1; cfg_index = 8'd9; cfg_pte = 32'h8000_0033;
        req_valid = 1'b1; req_vaddr = 16'h0944; req_write = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        chk_rsp("R8 collision old", 1'b1, 1'b0, 2'b01, 16'h0);
        one_req(16'h0944, 1'b0);
        chk_rsp("R8 after write", 1'b1, 1'b1, 2'b00, 16'h3344);

        // R4 R8 unmapping a page
        cfg_write(8'd47, 32'h0000_000A);
        one_req(16'h2F4B, 1'b0);
        chk_rsp("R4 unmapped", 1'b1, 1'b0, 2'b01, 16'h0);

        // R7 reset wipes mapped entries
        do_reset();
        one_req(16'h0511, 1'b0);
        chk_rsp("R7 after reset", 1'b1, 1'b0, 2'b01, 16'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule